// File: doc/BRIEF.md
# Configuration-Space Capability Walker

This block is a small bus master that traverses the linked list of capabilities in one function's PCI configuration space. It issues reads through a simple request/response port, decodes each capability header, and picks out the vendor-specific entries that a paravirtual device uses to describe where its register regions live. For each region kind it keeps the BAR index, byte offset and byte length, and it also keeps the doorbell stride multiplier and the configuration offset of the indirect-access window capability.

A scan is launched with a one-cycle `start`. When the walk ends, `done` pulses for one cycle. At that point `ok` tells whether all five required kinds were seen, and `err` tells whether the walk was cut short by the hop limit. The captured fields stay valid until the next scan begins. The surrounding firmware or sequencer then uses these records to reach the device's registers.

Top module: `capscan_top`

## Requirements
- R1: On `start`, the first request is a byte read of configuration address 0x34, and the pointer is taken from `rsp_data[7:0]`. A pointer of 0 ends the scan at once with `seen_mask`=0, `ok`=0, `err`=0 and `first_off`=0xFF.
- R2: Each capability header is fetched with one dword read at the capability's own offset. The header fields are split little-endian: ID in `rsp_data[7:0]`, next pointer in [15:8], length in [23:16] and sub-type in [31:24].
- R3: A capability qualifies only when its ID is 0x09 and its length is 16 or more. Any other capability causes no further read and no state change, and the walk moves straight to its next pointer.
- R4: A qualifying sub-type k in 1..5 sets bit k-1 of `seen_mask`. `ok` is 1 at `done` only when `seen_mask` is 0x1F.
- R5: A qualifying sub-type k in 1..4 causes three reads: a byte read at +4 for the BAR, a dword read at +8 for the offset and a dword read at +12 for the length. The results go into slot k-1, where slot s occupies bits [s*8+:8] of `region_bar` and bits [s*32+:32] of `region_off` and `region_len`. A later capability of the same sub-type overwrites the slot.
- R6: A qualifying sub-type 2 also causes a dword read at +16, which is stored in `notify_mult`.
- R7: A qualifying sub-type 5 stores its own capability offset in `window_off`, with no extra read. A qualifying sub-type of 0 or of 6 and above sets no mask bit and captures nothing.
- R8: `first_off` holds the offset of the first qualifying capability in list order, or 0xFF if there is none.
- R9: After MAX_HOPS (48) capability headers have been read, a nonzero next pointer ends the scan with `err`=1 and `ok`=0. A list of exactly MAX_HOPS entries that ends in 0 completes without error.
- R10: `req_valid`, `req_addr` and `req_dword` stay stable until `req_ready` is seen. Only one read is outstanding at a time, and a response of any latency is accepted.
- R11: `start` clears every captured field, including the region slots, `notify_mult`, `ok` and `err`. `done` is a single-cycle pulse. `start` is ignored while a scan is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (one-cycle pulse) |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 8 | Configuration byte address |
| req_dword | output | 1 | 1 = dword read, 0 = byte read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data (a byte read returns the byte in [7:0]) |
| done | output | 1 | Scan finished (one-cycle pulse) |
| ok | output | 1 | All five sub-types seen |
| err | output | 1 | Hop limit reached |
| seen_mask | output | 5 | Sub-types seen, bit k-1 for sub-type k |
| first_off | output | 8 | Offset of first qualifying capability or 0xFF |
| window_off | output | 8 | Offset of the sub-type 5 capability or 0xFF |
| notify_mult | output | 32 | Doorbell multiplier from sub-type 2 |
| region_bar | output | 32 | BAR byte per slot 0..3 |
| region_off | output | 128 | Region offset per slot 0..3 |
| region_len | output | 128 | Region length per slot 0..3 |

## Verification
The hardest cases to reach are the hop-limit abort and its boundary. The bench builds a two-entry cycle in its configuration-space model to drive the abort, and it builds a chain of exactly 48 plain capabilities to show that the limit does not fire early. Filtering and dispatch are observed at the ports by counting byte and dword requests against totals worked out from the list layout. A short vendor entry, a foreign ID, an unknown sub-type and a duplicate sub-type are mixed into one list for this purpose. The request and response latency is stretched with stalled ready cycles, and a second `start` is injected mid-walk to show it has no effect.

// File: rtl/capscan_pkg.sv
package capscan_pkg;
  localparam int CFG_AW      = 8;
  localparam int WORD_W      = 32;
  localparam int NUM_TYPES   = 5;
  localparam int NUM_REGIONS = 4;

  localparam logic [CFG_AW-1:0] CAP_PTR_ADDR  = 8'h34;
  localparam logic [7:0]        VENDOR_CAP_ID = 8'h09;
  localparam logic [7:0]        MIN_CAP_LEN   = 8'd16;
  localparam logic [CFG_AW-1:0] NO_OFFSET     = 8'hFF;
  localparam logic [7:0]        TYPE_NOTIFY   = 8'd2;
  localparam logic [7:0]        TYPE_WINDOW   = 8'd5;

  typedef enum logic [2:0] {STEP_PTR, STEP_HDR, STEP_BAR, STEP_OFF, STEP_LEN, STEP_MUL} step_e;
  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_RSP} phase_e;
  typedef enum logic [1:0] {FLD_BAR, FLD_OFF, FLD_LEN} field_e;
endpackage

// File: rtl/capscan_region_table.sv
module capscan_region_table
  import capscan_pkg::*;
#(
  parameter int SLOTS = NUM_REGIONS,
  parameter int DW    = WORD_W,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_slot,
  input  field_e            wr_fld,
  input  logic [DW-1:0]     wr_data,
  output logic [SLOTS*8-1:0]  bar_o,
  output logic [SLOTS*DW-1:0] off_o,
  output logic [SLOTS*DW-1:0] len_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        bar_o[g*8 +: 8]   <= '0;
        off_o[g*DW +: DW] <= '0;
        len_o[g*DW +: DW] <= '0;
      end else if (wr_en && wr_slot == SW'(g)) begin
        case (wr_fld)
          FLD_BAR: bar_o[g*8 +: 8]   <= wr_data[7:0];
          FLD_OFF: off_o[g*DW +: DW] <= wr_data;
          FLD_LEN: len_o[g*DW +: DW] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R11: a clear empties every slot on the next cycle
  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bar_o == '0 && off_o == '0 && len_o == '0));
endmodule

// File: rtl/capscan_walk_ctrl.sv
module capscan_walk_ctrl
  import capscan_pkg::*;
#(
  parameter int MAX_HOPS = 48,
  localparam int HW = $clog2(MAX_HOPS + 1),
  localparam int SW = $clog2(NUM_REGIONS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [CFG_AW-1:0]     req_addr,
  output logic                  req_dword,
  input  logic                  rsp_valid,
  input  logic [WORD_W-1:0]     rsp_data,
  output logic                  done,
  output logic                  ok,
  output logic                  err,
  output logic [NUM_TYPES-1:0]  seen_mask,
  output logic [CFG_AW-1:0]     first_off,
  output logic [CFG_AW-1:0]     window_off,
  output logic [WORD_W-1:0]     notify_mult,
  output logic                  tbl_clr,
  output logic                  tbl_wr,
  output logic [SW-1:0]         tbl_slot,
  output field_e                tbl_fld,
  output logic [WORD_W-1:0]     tbl_data
);
  localparam logic [NUM_TYPES-1:0] ALL_SEEN = {NUM_TYPES{1'b1}};

  phase_e            phase;
  step_e             step;
  logic [CFG_AW-1:0] cur_off;
  logic [7:0]        next_r;
  logic [7:0]        type_r;
  logic [HW-1:0]     hops;

  // header decode
  logic [7:0]           h_id, h_next, h_len, h_type;
  logic                 h_qual, h_region;
  logic [NUM_TYPES-1:0] h_bit, seen_upd;
  logic                 got, leave_cap;
  logic [7:0]           nxt_ptr;
  logic [HW-1:0]        hops_now;

  assign h_id   = rsp_data[7:0];
  assign h_next = rsp_data[15:8];
  assign h_len  = rsp_data[23:16];
  assign h_type = rsp_data[31:24];
  assign h_qual = (h_id == VENDOR_CAP_ID) && (h_len >= MIN_CAP_LEN);
  assign h_region = (h_type >= 8'd1) && (h_type <= 8'(NUM_REGIONS));
  assign got    = (phase == PH_RSP) && rsp_valid;

  always_comb begin
    for (int i = 0; i < NUM_TYPES; i++) h_bit[i] = (h_type == 8'(i + 1));
    seen_upd = seen_mask;
    if (got && step == STEP_HDR && h_qual) seen_upd = seen_mask | h_bit;
  end

  assign leave_cap = got && ((step == STEP_HDR && !(h_qual && h_region)) ||
                             (step == STEP_LEN && type_r != TYPE_NOTIFY) ||
                             (step == STEP_MUL));
  assign nxt_ptr  = (step == STEP_HDR) ? h_next : next_r;
  assign hops_now = (step == STEP_HDR) ? hops + HW'(1) : hops;

  // request port: decoded from registered state only
  assign req_valid = (phase == PH_REQ);
  always_comb begin
    req_addr  = cur_off;
    req_dword = 1'b1;
    case (step)
      STEP_PTR: begin req_addr = CAP_PTR_ADDR; req_dword = 1'b0; end
      STEP_HDR: req_addr = cur_off;
      STEP_BAR: begin req_addr = cur_off + 8'd4; req_dword = 1'b0; end
      STEP_OFF: req_addr = cur_off + 8'd8;
      STEP_LEN: req_addr = cur_off + 8'd12;
      STEP_MUL: req_addr = cur_off + 8'd16;
      default:  ;
    endcase
  end

  // region table writes
  assign tbl_clr  = (phase == PH_IDLE) && start;
  assign tbl_wr   = got && (step == STEP_BAR || step == STEP_OFF || step == STEP_LEN);
  assign tbl_slot = SW'(type_r - 8'd1);
  assign tbl_fld  = (step == STEP_BAR) ? FLD_BAR : (step == STEP_OFF) ? FLD_OFF : FLD_LEN;
  assign tbl_data = (step == STEP_BAR) ? {{(WORD_W-8){1'b0}}, rsp_data[7:0]} : rsp_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; step <= STEP_PTR; cur_off <= '0; next_r <= '0; type_r <= '0;
      hops <= '0; done <= 1'b0; ok <= 1'b0; err <= 1'b0; seen_mask <= '0;
      first_off <= NO_OFFSET; window_off <= NO_OFFSET; notify_mult <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          seen_mask <= '0; first_off <= NO_OFFSET; window_off <= NO_OFFSET;
          notify_mult <= '0; ok <= 1'b0; err <= 1'b0; hops <= '0;
          step <= STEP_PTR; phase <= PH_REQ;
        end
        PH_REQ: if (req_ready) phase <= PH_RSP;
        PH_RSP: if (rsp_valid) begin
          phase <= PH_REQ;
          seen_mask <= seen_upd;
          case (step)
            STEP_PTR: begin
              cur_off <= rsp_data[7:0];
              step    <= STEP_HDR;
              if (rsp_data[7:0] == 8'd0) begin
                phase <= PH_IDLE; done <= 1'b1; ok <= 1'b0;
              end
            end
            STEP_HDR: begin
              hops   <= hops_now;
              next_r <= h_next;
              type_r <= h_type;
              if (h_qual) begin
                if (first_off == NO_OFFSET) first_off <= cur_off;
                if (h_type == TYPE_WINDOW) window_off <= cur_off;
                if (h_region) step <= STEP_BAR;
              end
            end
            STEP_BAR: step <= STEP_OFF;
            STEP_OFF: step <= STEP_LEN;
            STEP_LEN: if (type_r == TYPE_NOTIFY) step <= STEP_MUL;
            STEP_MUL: notify_mult <= rsp_data;
            default:  ;
          endcase
          if (leave_cap) begin
            if (nxt_ptr == 8'd0) begin
              phase <= PH_IDLE; done <= 1'b1; ok <= (seen_upd == ALL_SEEN);
            end else if (hops_now >= HW'(MAX_HOPS)) begin
              phase <= PH_IDLE; done <= 1'b1; err <= 1'b1; ok <= 1'b0;
            end else begin
              cur_off <= nxt_ptr; step <= STEP_HDR;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10: a stalled request keeps its address and size
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_dword)));
  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: an aborted walk never reports success
  assert_err_not_ok_R9: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> !ok);
  // R9: header count never passes the limit
  assert_hops_bound_R9: assert property (@(posedge clk) disable iff (rst)
    hops <= HW'(MAX_HOPS));
  // R4: success implies the full mask
  assert_ok_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (done && ok) |-> (seen_mask == ALL_SEEN));
endmodule

// File: rtl/capscan_top.sv
module capscan_top
  import capscan_pkg::*;
#(
  parameter int MAX_HOPS = 48
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [CFG_AW-1:0]             req_addr,
  output logic                          req_dword,
  input  logic                          rsp_valid,
  input  logic [WORD_W-1:0]             rsp_data,
  output logic                          done,
  output logic                          ok,
  output logic                          err,
  output logic [NUM_TYPES-1:0]          seen_mask,
  output logic [CFG_AW-1:0]             first_off,
  output logic [CFG_AW-1:0]             window_off,
  output logic [WORD_W-1:0]             notify_mult,
  output logic [NUM_REGIONS*8-1:0]      region_bar,
  output logic [NUM_REGIONS*WORD_W-1:0] region_off,
  output logic [NUM_REGIONS*WORD_W-1:0] region_len
);
  localparam int SW = $clog2(NUM_REGIONS);

  logic              tbl_clr, tbl_wr;
  logic [SW-1:0]     tbl_slot;
  field_e            tbl_fld;
  logic [WORD_W-1:0] tbl_data;

  capscan_walk_ctrl #(.MAX_HOPS(MAX_HOPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_dword(req_dword),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .ok(ok), .err(err), .seen_mask(seen_mask),
    .first_off(first_off), .window_off(window_off), .notify_mult(notify_mult),
    .tbl_clr(tbl_clr), .tbl_wr(tbl_wr), .tbl_slot(tbl_slot), .tbl_fld(tbl_fld), .tbl_data(tbl_data)
  );

  capscan_region_table #(.SLOTS(NUM_REGIONS), .DW(WORD_W)) u_table (
    .clk(clk), .rst(rst), .clr(tbl_clr), .wr_en(tbl_wr), .wr_slot(tbl_slot),
    .wr_fld(tbl_fld), .wr_data(tbl_data),
    .bar_o(region_bar), .off_o(region_off), .len_o(region_len)
  );
endmodule

// File: tb/capscan_top_tb_top.sv
module capscan_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic req_valid, req_ready = 1'b0, req_dword;
  logic [7:0] req_addr;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic done, ok, err;
  logic [4:0] seen_mask;
  logic [7:0] first_off, window_off;
  logic [31:0] notify_mult, region_bar;
  logic [127:0] region_off, region_len;

  int n_tests = 0, n_fail = 0;
  logic [7:0] cfg [256];
  int acc_cnt = 0, rsp_cnt = 0, byte_cnt = 0, dly = 0, lat = 0, tick = 0;
  logic [7:0] acc_addr;
  logic acc_dw;
  logic res_ok, res_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  capscan_top dut_i (
    .clk(clk), .rst(rst), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_dword(req_dword),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .ok(ok), .err(err), .seen_mask(seen_mask),
    .first_off(first_off), .window_off(window_off), .notify_mult(notify_mult),
    .region_bar(region_bar), .region_off(region_off), .region_len(region_len)
  );

  // configuration-space model
  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      acc_cnt  <= acc_cnt + 1;
      acc_addr <= req_addr;
      acc_dw   <= req_dword;
      if (!req_dword) byte_cnt <= byte_cnt + 1;
    end
  end

  always @(negedge clk) begin
    tick++;
    req_ready = (lat == 0) ? 1'b1 : ((tick % 3) != 0);
    rsp_valid = 1'b0;
    if (acc_cnt != rsp_cnt) begin
      if (dly > 0) dly--;
      else begin
        rsp_valid = 1'b1;
        rsp_data  = acc_dw ? {cfg[8'(acc_addr+3)], cfg[8'(acc_addr+2)], cfg[8'(acc_addr+1)], cfg[acc_addr]}
                           : {24'h0, cfg[acc_addr]};
        rsp_cnt++;
        dly = lat;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 256; i++) cfg[i] = 8'h00;
  endtask

  task automatic put_w(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) cfg[(a + i) % 256] = v[i*8 +: 8];
  endtask

  task automatic put_cap(input int a, input logic [7:0] id, input logic [7:0] nxt, input logic [7:0] len,
                         input logic [7:0] typ, input logic [7:0] bar, input logic [31:0] o,
                         input logic [31:0] l, input logic [31:0] m);
    put_w(a, {typ, len, nxt, id});
    cfg[a + 4] = bar;
    put_w(a + 8, o);
    put_w(a + 12, l);
    if (len >= 20) put_w(a + 16, m);
  endtask

  task automatic run_scan(input bool_extra);
    int cnt;
    acc_cnt = 0; rsp_cnt = 0; byte_cnt = 0; dly = lat;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (!done && cnt < 20000) begin
      if (bool_extra && cnt == 5) start = 1'b1;
      if (bool_extra && cnt == 6) start = 1'b0;
      @(negedge clk); cnt++;
    end
    start = 1'b0;
    res_ok = ok; res_err = err;
    @(negedge clk);
  endtask

  task automatic build_full();
    clear_cfg();
    cfg[8'h34] = 8'h40;
    put_cap(8'h40, 8'h05, 8'h50, 8'h18, 8'h01, 8'h07, 32'hDEAD, 32'hBEEF, 0);
    put_cap(8'h50, 8'h09, 8'h60, 8'd12, 8'h01, 8'h07, 32'h1111, 32'h2222, 0);
    put_cap(8'h60, 8'h09, 8'h74, 8'd16, 8'h01, 8'h02, 32'h0000_1000, 32'h100, 0);
    put_cap(8'h74, 8'h09, 8'h8c, 8'd20, 8'h02, 8'h04, 32'h0000_3000, 32'h400, 32'h4);
    put_cap(8'h8c, 8'h09, 8'ha0, 8'd16, 8'h03, 8'h01, 32'h0000_2000, 32'h20, 0);
    put_cap(8'ha0, 8'h09, 8'hb4, 8'd16, 8'h04, 8'h03, 32'h0000_4000, 32'h80, 0);
    put_cap(8'hb4, 8'h09, 8'h00, 8'd20, 8'h05, 8'h00, 0, 0, 0);
  endtask

  task automatic check_full(input string tag);
    chk({tag, " R4 ok"}, 32'(res_ok), 1);
    chk({tag, " R9 err"}, 32'(res_err), 0);
    chk({tag, " R4 mask"}, 32'(seen_mask), 32'h1F);
    chk({tag, " R8 first_off"}, 32'(first_off), 32'h60);
    chk({tag, " R7 window_off"}, 32'(window_off), 32'hB4);
    chk({tag, " R6 notify_mult"}, notify_mult, 32'h4);
    chk({tag, " R5 bars"}, region_bar, 32'h03_01_04_02);
    chk({tag, " R5 off0"}, region_off[0 +: 32], 32'h1000);
    chk({tag, " R5 off1"}, region_off[32 +: 32], 32'h3000);
    chk({tag, " R5 off2"}, region_off[64 +: 32], 32'h2000);
    chk({tag, " R5 off3"}, region_off[96 +: 32], 32'h4000);
    chk({tag, " R5 len0"}, region_len[0 +: 32], 32'h100);
    chk({tag, " R5 len1"}, region_len[32 +: 32], 32'h400);
    chk({tag, " R5 len3"}, region_len[96 +: 32], 32'h80);
    // R3: 1 pointer + 7 headers + 4*3 region reads + 1 multiplier
    chk({tag, " R3 request count"}, 32'(acc_cnt), 21);
    // R2/R1: byte reads only for the pointer and the four BAR bytes
    chk({tag, " R2 byte reads"}, 32'(byte_cnt), 5);
  endtask

  task automatic t_reset();
    chk("R11 reset done", 32'(done), 0);
    chk("R11 reset ok", 32'(ok), 0);
    chk("R8 reset first_off", 32'(first_off), 32'hFF);
    chk("R4 reset mask", 32'(seen_mask), 0);
    chk("R10 reset req_valid", 32'(req_valid), 0);
  endtask

  task automatic t_full();
    lat = 0; build_full(); run_scan(1'b0);
    check_full("full");
  endtask

  task automatic t_empty_after_full();
    lat = 1; clear_cfg(); run_scan(1'b0);
    chk("R1 empty ok", 32'(res_ok), 0);
    chk("R1 empty err", 32'(res_err), 0);
    chk("R1 empty mask", 32'(seen_mask), 0);
    chk("R1 empty first_off", 32'(first_off), 32'hFF);
    chk("R1 empty requests", 32'(acc_cnt), 1);
    chk("R11 cleared bars", region_bar, 0);
    chk("R11 cleared off1", region_off[32 +: 32], 0);
    chk("R11 cleared mult", notify_mult, 0);
    chk("R7 cleared window", 32'(window_off), 32'hFF);
  endtask

  task automatic t_partial_dup();
    lat = 2; clear_cfg();
    cfg[8'h34] = 8'h40;
    put_cap(8'h40, 8'h09, 8'h50, 8'd16, 8'h07, 8'h09, 32'h1, 32'h2, 0);
    put_cap(8'h50, 8'h09, 8'h60, 8'd16, 8'h01, 8'h05, 32'hAAAA_0000, 32'h10, 0);
    put_cap(8'h60, 8'h09, 8'h70, 8'd16, 8'h01, 8'h06, 32'hBBBB_0000, 32'h20, 0);
    put_cap(8'h70, 8'h09, 8'h00, 8'd16, 8'h05, 8'h00, 0, 0, 0);
    run_scan(1'b0);
    chk("R4 partial ok", 32'(res_ok), 0);
    chk("R4 partial mask", 32'(seen_mask), 32'h11);
    chk("R8 partial first_off unknown type", 32'(first_off), 32'h40);
    chk("R7 partial window_off", 32'(window_off), 32'h70);
    chk("R5 duplicate bar", region_bar, 32'h06);
    chk("R5 duplicate off", region_off[0 +: 32], 32'hBBBB_0000);
    chk("R5 duplicate len", region_len[0 +: 32], 32'h20);
    chk("R7 unknown type no reads", 32'(acc_cnt), 11);
  endtask

  task automatic t_loop();
    lat = 1; clear_cfg();
    cfg[8'h34] = 8'h40;
    put_w(8'h40, {8'h00, 8'h04, 8'h50, 8'h05});
    put_w(8'h50, {8'h00, 8'h04, 8'h40, 8'h05});
    run_scan(1'b0);
    chk("R9 loop err", 32'(res_err), 1);
    chk("R9 loop ok", 32'(res_ok), 0);
    chk("R9 loop requests", 32'(acc_cnt), 49);
  endtask

  task automatic t_exact_limit();
    lat = 0; clear_cfg();
    cfg[8'h34] = 8'h40;
    for (int i = 0; i < 48; i++) begin
      logic [7:0] nx;
      nx = (i == 47) ? 8'h00 : 8'(8'h40 + 4 * (i + 1));
      put_w(8'h40 + 4 * i, {8'h00, 8'h04, nx, 8'h10});
    end
    run_scan(1'b0);
    chk("R9 exact limit err", 32'(res_err), 0);
    chk("R9 exact limit requests", 32'(acc_cnt), 49);
  endtask

  task automatic t_busy_start();
    lat = 2; build_full(); run_scan(1'b1);
    check_full("busy-start R11");
  endtask

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_empty_after_full();
    t_partial_dup();
    t_loop();
    t_exact_limit();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule